// File: doc/BRIEF.md
# Card Security Code Verifier

This block is the access-control core of a synchronous memory card. It holds an 8-bit attempt counter and a two-byte security code, which sit at the top three addresses of the card's array. It decides whether any write reaches the rest of memory. Writing to the card is refused until the holder proves knowledge of the code.

A verification attempt always costs one counter bit. The host first issues a "consume counter bit" command. The block then accepts a compare of the low code byte, followed by a compare of the high code byte. The grant is raised only when both bytes matched within the same attempt. A failed or interrupted attempt leaves the consumed bit cleared. Once every counter bit has been spent, no attempt can be started again. After a success, the host may restore the counter to all ones, rewrite the code bytes (unless the lock input forbids it), and write ordinary memory.

The grant is volatile: a card power-up pulse drops it without touching the counter or the code. Reads pass through a mask:
- the code bytes always read as zero;
- the counter address returns the live counter;
- every other address returns the array's data unchanged.

Top module: `sec_code_gate`

## Requirements
- R1: After the hard reset `rstN` is released, `grant` is 0, the counter address (1021) reads 0xFF and the code addresses read 0x00.
- R2: `rdData` is combinational on `rdAddr`. Addresses 1022 and 1023 always return 0. Address 1021 returns the current counter. Any lower address returns `memRdData`.
- R3: Command 1 (consume bit) clears the lowest-numbered set bit of the counter and opens an attempt. If the counter is already 0, the command changes nothing and opens no attempt.
- R4: Commands 2 (compare low byte) and 3 (compare high byte) are ignored while no attempt is open. In particular, they do not raise `grant`.
- R5: Within an open attempt, command 2 records whether `cmdData` equals the low code byte. A following command 3 closes the attempt and sets `grant` to 1 only if the recorded low match held and `cmdData` equals the high code byte; otherwise it sets `grant` to 0. A command 3 issued before any command 2 in the attempt is ignored. All of these effects are visible after one clock edge.
- R6: Once the counter reaches 0, no sequence of commands can raise `grant` until the hard reset.
- R7: Command 4 (erase counter) sets the counter to 0xFF only while `grant` is 1, and is ignored otherwise. A successful verification never restores the counter by itself.
- R8: Command 5 (write) with `grant` at 1 and `cmdAddr` below 1021 produces a one-cycle `memWrEn` pulse one edge later, with `memWrAddr`/`memWrData` carrying the command's address and data. In every other case, `memWrEn` stays 0.
- R9: Command 5 to address 1022 or 1023 replaces the low or high code byte only while `grant` is 1 and `codeLock` is 0. A command 5 to 1021 never changes the counter.
- R10: A `powerUp` pulse clears `grant` and any open attempt but leaves the counter and the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hard reset; restores the counter to 0xFF and the code to its initial value |
| powerUp | input | 1 | Card power-up pulse; drops the grant and any open attempt |
| cmdValid | input | 1 | A decoded command is present this cycle |
| cmdOp | input | 3 | Command: 1 consume bit, 2 compare low, 3 compare high, 4 erase counter, 5 write, others no-op |
| cmdAddr | input | 10 | Address for a write command |
| cmdData | input | 8 | Compare byte or write data |
| codeLock | input | 1 | Protection of the code bytes; 1 forbids rewriting them |
| rdAddr | input | 10 | Read address |
| memRdData | input | 8 | Data read from the array at `rdAddr` |
| rdData | output | 8 | Masked read data |
| grant | output | 1 | Write and erase access granted |
| memWrEn | output | 1 | Write strobe towards the array |
| memWrAddr | output | 10 | Address of the array write |
| memWrData | output | 8 | Data of the array write |

## Verification
The block's results follow a single-edge rule:
- `grant`, `memWrEn` and the counter all change at the first rising edge after the command is presented.
- `rdData` is combinational, so it shows the state after that edge as soon as it settles.

The bench drives every command and read address on the falling edge and samples all outputs at the next falling edge. The expected values come from a bench model stepped once per command, and the expected write strobe is derived from the model's state before that step. Random phases each start from a hard reset, so attempts do not run out the counter before the comparisons have been exercised.

// File: rtl/scg_pkg.sv
package scg_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_EC_CLR   = 3'd1,
    OP_CMP_LO   = 3'd2,
    OP_CMP_HI   = 3'd3,
    OP_EC_ERASE = 3'd4,
    OP_WRITE    = 3'd5
  } op_e;

  typedef struct packed {
    logic ecClr;
    logic ecErase;
    logic codeLdLo;
    logic codeLdHi;
    logic memWr;
  } strobe_t;
endpackage

// File: rtl/scg_ctrl.sv
module scg_ctrl
  import scg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerUp,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              codeLock,
  input  logic              ecEmpty,
  input  logic              loMatch,
  input  logic              hiMatch,
  output strobe_t           stb,
  output logic              grant
);
  localparam logic [ADDR_W-1:0] EC_ADDR = ADDR_W'((1 << ADDR_W) - 3);
  localparam logic [ADDR_W-1:0] CODE_LO = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] CODE_HI = ADDR_W'((1 << ADDR_W) - 1);

  op_e  op;
  logic armed;   // attempt open: a counter bit was consumed
  logic loSeen;  // low byte compared in this attempt
  logic loOk;    // result of that low byte compare

  assign op = op_e'(cmdOp);

  always_comb begin
    stb = '0;
    if (cmdValid) begin
      case (op)
        OP_EC_CLR:   stb.ecClr   = !ecEmpty;
        OP_EC_ERASE: stb.ecErase = grant;
        OP_WRITE: begin
          if (grant) begin
            stb.memWr    = (cmdAddr < EC_ADDR);
            stb.codeLdLo = (cmdAddr == CODE_LO) && !codeLock;
            stb.codeLdHi = (cmdAddr == CODE_HI) && !codeLock;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || powerUp) begin
      grant  <= 1'b0;
      armed  <= 1'b0;
      loSeen <= 1'b0;
      loOk   <= 1'b0;
    end else if (cmdValid) begin
      case (op)
        OP_EC_CLR: begin
          if (!ecEmpty) begin
            armed  <= 1'b1;
            loSeen <= 1'b0;
            loOk   <= 1'b0;
          end
        end
        OP_CMP_LO: begin
          if (armed) begin
            loSeen <= 1'b1;
            loOk   <= loMatch;
          end
        end
        OP_CMP_HI: begin
          if (armed && loSeen) begin
            grant  <= loOk && hiMatch;
            armed  <= 1'b0;
            loSeen <= 1'b0;
            loOk   <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scg_dp.sv
module scg_dp
  import scg_pkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter int              DATA_W    = 8,
  parameter logic [2*DATA_W-1:0] CODE_INIT = 16'h5AC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              ecEmpty,
  output logic              loMatch,
  output logic              hiMatch,
  output logic [DATA_W-1:0] ecNow,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  localparam logic [ADDR_W-1:0] EC_ADDR = ADDR_W'((1 << ADDR_W) - 3);
  localparam logic [ADDR_W-1:0] CODE_LO = ADDR_W'((1 << ADDR_W) - 2);

  logic [DATA_W-1:0] errCnt;
  logic [DATA_W-1:0] codeLo;
  logic [DATA_W-1:0] codeHi;

  assign ecNow   = errCnt;
  assign ecEmpty = (errCnt == '0);
  assign loMatch = (cmdData == codeLo);
  assign hiMatch = (cmdData == codeHi);

  always_comb begin
    if (rdAddr >= CODE_LO)      rdData = '0;
    else if (rdAddr == EC_ADDR) rdData = errCnt;
    else                        rdData = memRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCnt    <= '1;
      codeLo    <= CODE_INIT[DATA_W-1:0];
      codeHi    <= CODE_INIT[2*DATA_W-1:DATA_W];
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
    end else begin
      if (stb.ecErase)    errCnt <= '1;
      else if (stb.ecClr) errCnt <= errCnt & (errCnt - DATA_W'(1));
      if (stb.codeLdLo) codeLo <= cmdData;
      if (stb.codeLdHi) codeHi <= cmdData;
      memWrEn <= stb.memWr;
      if (stb.memWr) begin
        memWrAddr <= cmdAddr;
        memWrData <= cmdData;
      end
    end
  end
endmodule

// File: rtl/sec_code_gate.sv
module sec_code_gate
  import scg_pkg::*;
#(
  parameter int                  ADDR_W    = 10,
  parameter int                  DATA_W    = 8,
  parameter logic [2*DATA_W-1:0] CODE_INIT = 16'h5AC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerUp,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              codeLock,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] rdData,
  output logic              grant,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  strobe_t           stb;
  logic              ecEmpty;
  logic              loMatch;
  logic              hiMatch;
  logic [DATA_W-1:0] ecNow;

  scg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .powerUp(powerUp),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .codeLock(codeLock), .ecEmpty(ecEmpty),
    .loMatch(loMatch), .hiMatch(hiMatch),
    .stb(stb), .grant(grant)
  );

  scg_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_INIT(CODE_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cmdAddr(cmdAddr), .cmdData(cmdData),
    .rdAddr(rdAddr), .memRdData(memRdData), .rdData(rdData),
    .ecEmpty(ecEmpty), .loMatch(loMatch), .hiMatch(hiMatch),
    .ecNow(ecNow),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );
endmodule

// File: rtl/sec_code_gate_chk.sv
module sec_code_gate_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              powerUp,
  input logic              cmdValid,
  input logic [2:0]        cmdOp,
  input logic              grant,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] ecNow
);
  localparam logic [ADDR_W-1:0] CODE_LO = ADDR_W'((1 << ADDR_W) - 2);

  // R2: code bytes never leave the block
  p_code_hidden_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr >= CODE_LO) |-> (rdData == '0));

  // R3: a consume command on a non-empty counter removes exactly one bit
  p_one_bit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd1 && ecNow != '0 && !powerUp && !(grant && 1'b0))
      |=> ($countones(ecNow) + 1 == $countones($past(ecNow))));

  // R5: grant only rises as the result of a high byte compare
  p_grant_source_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grant) |-> $past(cmdValid && cmdOp == 3'd3));

  // R7: counter bits only come back through an erase while granted
  p_ec_restore_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((ecNow & ~$past(ecNow)) != '0) |-> $past(cmdValid && cmdOp == 3'd4 && grant));

  // R8: array writes only follow a granted cycle
  p_wr_granted_r8: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(grant));

  // R10: power-up drops the grant
  p_power_drop_r10: assert property (@(posedge clk) disable iff (!rstN)
    powerUp |=> !grant);
endmodule

bind sec_code_gate sec_code_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .powerUp(powerUp), .cmdValid(cmdValid),
  .cmdOp(cmdOp), .grant(grant), .memWrEn(memWrEn),
  .rdAddr(rdAddr), .rdData(rdData), .ecNow(ecNow)
);

// File: tb/sec_code_gate_bench.sv
module sec_code_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam logic [15:0] CODE_INIT = 16'h5AC3;
  localparam int EC_A = 1021, LO_A = 1022, HI_A = 1023;

  logic clk = 1'b0;
  logic rstN = 1'b0, powerUp = 1'b0, cmdValid = 1'b0, codeLock = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [ADDR_W-1:0] cmdAddr = '0, rdAddr = '0, memWrAddr;
  logic [DATA_W-1:0] cmdData = '0, memRdData = '0, rdData, memWrData;
  logic grant, memWrEn;

  int checkCnt = 0, failCnt = 0;
  bit done = 0;

  // bench model
  logic [7:0]  mEc;
  logic [15:0] mCode;
  logic mArmed, mLoSeen, mLoOk, mGrant;

  sec_code_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_INIT(CODE_INIT)) u_sec_code_gate (
    .clk(clk), .rstN(rstN), .powerUp(powerUp), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .codeLock(codeLock), .rdAddr(rdAddr),
    .memRdData(memRdData), .rdData(rdData), .grant(grant), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expRd(input logic [ADDR_W-1:0] a, input logic [7:0] m);
    if (a >= LO_A) return 8'h00;
    if (a == EC_A) return mEc;
    return m;
  endfunction

  function automatic logic [7:0] dropLowest(input logic [7:0] v);
    logic [7:0] r = v;
    for (int i = 0; i < 8; i++) if (v[i]) begin r[i] = 1'b0; break; end
    return r;
  endfunction

  task automatic modelReset();
    mEc = 8'hFF; mCode = CODE_INIT;
    mArmed = 0; mLoSeen = 0; mLoOk = 0; mGrant = 0;
  endtask

  task automatic hardReset();
    rstN = 1'b0; cmdValid = 1'b0; powerUp = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  // drive at falling edge, check at the next falling edge
  task automatic doCmd(input string req, input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [7:0] d, input logic [ADDR_W-1:0] ra, input logic [7:0] md);
    logic expWr;
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d; rdAddr = ra; memRdData = md;
    expWr = (op == 3'd5) && mGrant && (a < EC_A);
    case (op)
      3'd1: if (mEc != 0) begin mEc = dropLowest(mEc); mArmed = 1; mLoSeen = 0; mLoOk = 0; end
      3'd2: if (mArmed) begin mLoSeen = 1; mLoOk = (d == mCode[7:0]); end
      3'd3: if (mArmed && mLoSeen) begin
              mGrant = mLoOk && (d == mCode[15:8]); mArmed = 0; mLoSeen = 0; mLoOk = 0;
            end
      3'd4: if (mGrant) mEc = 8'hFF;
      3'd5: if (mGrant && !codeLock) begin
              if (a == LO_A) mCode[7:0] = d;
              if (a == HI_A) mCode[15:8] = d;
            end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk({req, " grant"}, {15'd0, grant}, {15'd0, mGrant});
    chk({req, " memWrEn"}, {15'd0, memWrEn}, {15'd0, expWr});
    if (expWr) begin
      chk({req, " memWrAddr"}, 16'(memWrAddr), 16'(a));
      chk({req, " memWrData"}, 16'(memWrData), 16'(d));
    end
    chk({req, " rdData"}, 16'(rdData), 16'(expRd(ra, md)));
  endtask

  task automatic pulsePowerUp();
    powerUp = 1'b1; cmdValid = 1'b0;
    @(posedge clk); @(negedge clk);
    powerUp = 1'b0;
    mGrant = 0; mArmed = 0; mLoSeen = 0; mLoOk = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failCnt++; checkCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    modelReset();
    @(negedge clk);
    hardReset();
    // R1 reset state, R2 masking
    doCmd("R1", 3'd0, 0, 0, EC_A, 8'h00);
    chk("R1 ec after reset", 16'(rdData), 16'h00FF);
    doCmd("R2 code lo hidden", 3'd0, 0, 0, LO_A, 8'hEE);
    doCmd("R2 code hi hidden", 3'd0, 0, 0, HI_A, 8'hEE);
    doCmd("R2 passthrough", 3'd0, 0, 0, 10'd17, 8'h96);
    // R4 compare without attempt
    doCmd("R4 cmp lo", 3'd2, 0, CODE_INIT[7:0], EC_A, 0);
    doCmd("R4 cmp hi", 3'd3, 0, CODE_INIT[15:8], EC_A, 0);
    chk("R4 no grant", {15'd0, grant}, 16'd0);
    // R8 blocked write, R7 erase ignored
    doCmd("R8 blocked", 3'd5, 10'd5, 8'h11, 10'd5, 8'h22);
    doCmd("R3 consume", 3'd1, 0, 0, EC_A, 0);
    chk("R3 ec FE", 16'(rdData), 16'h00FE);
    doCmd("R7 erase ignored", 3'd4, 0, 0, EC_A, 0);
    chk("R7 ec still FE", 16'(rdData), 16'h00FE);
    // R5 wrong low byte
    doCmd("R5 cmp lo bad", 3'd2, 0, 8'h00, EC_A, 0);
    doCmd("R5 cmp hi", 3'd3, 0, CODE_INIT[15:8], EC_A, 0);
    doCmd("R5 hi no attempt", 3'd3, 0, CODE_INIT[15:8], EC_A, 0);
    // R5 success
    doCmd("R3 consume 2", 3'd1, 0, 0, EC_A, 0);
    doCmd("R5 hi before lo", 3'd3, 0, CODE_INIT[15:8], EC_A, 0);
    doCmd("R5 lo ok", 3'd2, 0, CODE_INIT[7:0], EC_A, 0);
    doCmd("R5 hi ok", 3'd3, 0, CODE_INIT[15:8], EC_A, 0);
    chk("R5 granted", {15'd0, grant}, 16'd1);
    chk("R7 no auto restore", 16'(rdData), 16'h00FC);
    // R8, R9
    doCmd("R8 write", 3'd5, 10'd7, 8'h3C, 10'd7, 8'h00);
    doCmd("R8 write top", 3'd5, 10'd1020, 8'hA1, 10'd1020, 8'h00);
    doCmd("R9 ec not writable", 3'd5, EC_A, 8'hFF, EC_A, 0);
    chk("R9 ec kept", 16'(rdData), 16'h00FC);
    doCmd("R7 erase", 3'd4, 0, 0, EC_A, 0);
    chk("R7 ec FF", 16'(rdData), 16'h00FF);
    codeLock = 1'b1;
    doCmd("R9 locked write", 3'd5, LO_A, 8'h11, LO_A, 0);
    codeLock = 1'b0;
    doCmd("R9 open write", 3'd5, LO_A, 8'h77, LO_A, 0);
    // R10 power-up
    pulsePowerUp();
    chk("R10 grant cleared", {15'd0, grant}, 16'd0);
    doCmd("R10 ec kept", 3'd0, 0, 0, EC_A, 0);
    chk("R10 ec value", 16'(rdData), 16'h00FF);
    // R9 verify new code works, old low byte fails
    doCmd("R9 consume", 3'd1, 0, 0, EC_A, 0);
    doCmd("R9 lo old", 3'd2, 0, CODE_INIT[7:0], EC_A, 0);
    doCmd("R9 hi", 3'd3, 0, CODE_INIT[15:8], EC_A, 0);
    doCmd("R9 consume", 3'd1, 0, 0, EC_A, 0);
    doCmd("R9 lo new", 3'd2, 0, 8'h77, EC_A, 0);
    doCmd("R9 hi", 3'd3, 0, CODE_INIT[15:8], EC_A, 0);
    chk("R9 new code grants", {15'd0, grant}, 16'd1);
    // R6 lockout
    pulsePowerUp();
    for (int i = 0; i < 8; i++) begin
      doCmd("R6 burn", 3'd1, 0, 0, EC_A, 0);
      doCmd("R6 bad lo", 3'd2, 0, 8'h00, EC_A, 0);
      doCmd("R6 hi", 3'd3, 0, mCode[15:8], EC_A, 0);
    end
    chk("R6 ec empty", 16'(rdData), 16'h0000);
    doCmd("R3 consume empty", 3'd1, 0, 0, EC_A, 0);
    doCmd("R6 lo good", 3'd2, 0, mCode[7:0], EC_A, 0);
    doCmd("R6 hi good", 3'd3, 0, mCode[15:8], EC_A, 0);
    chk("R6 locked out", {15'd0, grant}, 16'd0);
    // random phases
    for (int ph = 0; ph < 40; ph++) begin
      hardReset();
      codeLock = 1'($urandom_range(0, 1));
      for (int k = 0; k < 60; k++) begin
        int sel = $urandom_range(0, 9);
        logic [2:0] op;
        logic [7:0] d;
        logic [ADDR_W-1:0] a, ra;
        case (sel)
          0, 1: op = 3'd1;
          2, 3: op = 3'd2;
          4, 5: op = 3'd3;
          6:    op = 3'd4;
          7, 8: op = 3'd5;
          default: op = 3'($urandom_range(0, 7));
        endcase
        if ($urandom_range(0, 3) != 0) d = (op == 3'd3) ? mCode[15:8] : mCode[7:0];
        else d = 8'($urandom);
        a  = ($urandom_range(0, 1) != 0) ? ADDR_W'($urandom_range(1020, 1023)) : ADDR_W'($urandom);
        ra = ($urandom_range(0, 1) != 0) ? ADDR_W'($urandom_range(1020, 1023)) : ADDR_W'($urandom);
        doCmd("R2/R3/R5/R7/R8/R9 random", op, a, d, ra, 8'($urandom));
        if ($urandom_range(0, 40) == 0) pulsePowerUp();
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule